// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is an I2C target that gives a bus host read and write access to a bank of 8-bit control registers. SCL and SDA are sampled in a fast system clock domain. The system clock is expected to run at least ten times the SCL rate; bus rates up to 400 kHz are intended. The block finds START and STOP conditions, matches a fixed 7-bit device address and moves bytes MSB first. It drives SDA only through an open-drain enable: when `sdaOe` is high the pad pulls the line low.

A write transfer sets an internal byte pointer and then stores any number of data bytes at successive locations. A read transfer has no pointer phase. It returns bytes starting at the location the pointer holds after the last write or read. The pointer advances after every data byte in either direction and wraps from the top of the bank to zero. The host ends a read by leaving the acknowledge bit high, and the block then lets go of SDA.

Top module: `i2c_rb_slave`

## Requirements
- R1: The block acknowledges only a first byte whose upper seven bits equal binary 1000000, with bit 0 selecting read (1) or write (0). On any other address it never pulls SDA low until the next START or STOP.
- R2: SDA falling while SCL is high is a START, and it restarts address reception from any state, including in the middle of a transfer. SDA rising while SCL is high is a STOP, which ends the transfer and drops any partly received byte.
- R3: Incoming bits are sampled on SCL rising edges, MSB first. The block changes its SDA drive only while SCL is low.
- R4: In a write transfer the byte after the address loads the register pointer, and every following byte is stored in the register the pointer selects. The block acknowledges each of these bytes by pulling SDA low for the ninth clock.
- R5: The pointer increases by one after each stored byte and wraps from 255 to 0.
- R6: In a read transfer the block acknowledges the address and then sends the register at the current pointer, MSB first. The pointer increases by one after each byte sent, so a later read continues where the last transfer stopped.
- R7: An acknowledge from the host (SDA low on the ninth clock) makes the block send the next register. A not-acknowledge (SDA high) makes it release SDA until the next START or STOP.
- R8: After reset all 256 registers and the pointer are zero, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least ten times the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL level seen at the pad |
| sdaIn | input | 1 | SDA level seen at the pad |
| sdaOe | output | 1 | When high, the pad pulls SDA low |

## Verification
On every cycle the assertions check four things. SDA drive changes only while the synchronised SCL is low. The pointer either holds or moves by exactly one unless it is being loaded. An acknowledge phase for the address is entered only with a matching address byte. A START always returns control to address reception. Other behaviour needs whole transfers over the bus and only the bench's scenarios can show it: what ends up stored and read back, wrap-around at the top of the bank, continuation of the pointer across separate reads, release after a not-acknowledge, and a write dropped by a mid-byte STOP.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } busState_e;

  // Strobes from control to datapath, each one cycle wide
  typedef struct packed {
    logic shiftIn;   // sample SDA into the receive shifter
    logic countBit;  // count a transmitted bit
    logic clrCnt;    // restart the bit counter
    logic loadPtr;   // pointer <= received byte
    logic writeReg;  // bank[pointer] <= received byte
    logic incPtr;    // pointer <= pointer + 1
    logic loadTx;    // transmit shifter <= bank[pointer]
    logic shiftTx;   // present the next transmit bit
  } dpStrobe_t;

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  // Idle bus is high, so resetting to ones avoids false edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclS     = sclPipe[STAGES-1];
  assign sdaS     = sdaPipe[STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

endmodule

// File: rtl/i2c_rb_dp.sv
module i2c_rb_dp
  import i2c_rb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaS,
  output logic [BYTE_W-1:0] rxByte,
  output logic              cntFull,
  output logic              txMsb,
  output logic [ADDR_W-1:0] ptr
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] bank [DEPTH];
  logic [BYTE_W-1:0] txShift;
  logic [CNT_W-1:0]  bitCnt;

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        q <= '0;
      else if (stb.writeReg && ptr == ADDR_W'(g))
        q <= rxByte;
    end
    assign bank[g] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxByte  <= '0;
      txShift <= '1;
      ptr     <= '0;
    end else begin
      if (stb.clrCnt)
        bitCnt <= '0;
      else if (stb.shiftIn || stb.countBit)
        bitCnt <= bitCnt + 1'b1;

      if (stb.shiftIn)
        rxByte <= {rxByte[BYTE_W-2:0], sdaS};

      if (stb.loadPtr)
        ptr <= rxByte[ADDR_W-1:0];
      else if (stb.incPtr)
        ptr <= ptr + 1'b1;

      if (stb.loadTx)
        txShift <= bank[ptr];
      else if (stb.shiftTx)
        txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  assign cntFull = (bitCnt == CNT_W'(BYTE_W));
  assign txMsb   = txShift[BYTE_W-1];

endmodule

// File: rtl/i2c_rb_ctrl.sv
module i2c_rb_ctrl
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              sdaS,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              cntFull,
  input  logic              txMsb,
  input  logic [BYTE_W-1:0] rxByte,
  output dpStrobe_t         stb,
  output busState_e         state,
  output logic              sdaOe
);

  busState_e nextState;
  logic isRead, nextIsRead;
  logic hostAck, nextHostAck;

  always_comb begin
    nextState   = state;
    nextIsRead  = isRead;
    nextHostAck = hostAck;
    stb         = '0;
    if (startDet) begin
      nextState  = ST_ADDR;
      stb.clrCnt = 1'b1;
    end else if (stopDet) begin
      nextState  = ST_IDLE;
      stb.clrCnt = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (sclRise && !cntFull)
            stb.shiftIn = 1'b1;
          if (sclFall && cntFull) begin
            stb.clrCnt = 1'b1;
            if (state == ST_ADDR) begin
              if (rxByte[BYTE_W-1:1] == DEV_ADDR) begin
                nextState  = ST_ADDR_ACK;
                nextIsRead = rxByte[0];
              end else begin
                nextState = ST_IGNORE;
              end
            end else if (state == ST_PTR) begin
              stb.loadPtr = 1'b1;
              nextState   = ST_PTR_ACK;
            end else begin
              stb.writeReg = 1'b1;
              stb.incPtr   = 1'b1;
              nextState    = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (isRead) begin
              stb.loadTx = 1'b1;
              nextState  = ST_RDATA;
            end else begin
              nextState = ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          if (sclFall)
            nextState = ST_WDATA;
        end
        ST_RDATA: begin
          if (sclRise)
            stb.countBit = 1'b1;
          if (sclFall) begin
            if (cntFull) begin
              stb.incPtr = 1'b1;
              stb.clrCnt = 1'b1;
              nextState  = ST_RACK;
            end else begin
              stb.shiftTx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise)
            nextHostAck = ~sdaS;
          if (sclFall) begin
            if (hostAck) begin
              stb.loadTx = 1'b1;
              nextState  = ST_RDATA;
            end else begin
              nextState = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isRead  <= 1'b0;
      hostAck <= 1'b0;
    end else begin
      state   <= nextState;
      isRead  <= nextIsRead;
      hostAck <= nextHostAck;
    end
  end

  // Pull low during our acknowledge bits and for zero data bits
  always_comb begin
    unique case (state)
      ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sdaOe = 1'b1;
      ST_RDATA:                              sdaOe = ~txMsb;
      default:                               sdaOe = 1'b0;
    endcase
  end

endmodule

// File: rtl/i2c_rb_slave.sv
module i2c_rb_slave
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1000000,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  logic sclSync, sdaSync, sclRise, sclFall, startDet, stopDet;
  logic cntFull, txMsb;
  logic [BYTE_W-1:0] rxByte;
  logic [ADDR_W-1:0] ptrVal;
  dpStrobe_t stb;
  busState_e ctrlState;

  i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclSync), .sdaS(sdaSync), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_rb_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .sdaS(sdaSync), .startDet(startDet), .stopDet(stopDet),
    .cntFull(cntFull), .txMsb(txMsb), .rxByte(rxByte),
    .stb(stb), .state(ctrlState), .sdaOe(sdaOe)
  );

  i2c_rb_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaS(sdaSync),
    .rxByte(rxByte), .cntFull(cntFull), .txMsb(txMsb), .ptr(ptrVal)
  );

endmodule

// File: rtl/i2c_rb_chk.sv
module i2c_rb_chk
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000000,
  parameter int         ADDR_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclSync,
  input logic              startDet,
  input dpStrobe_t         stb,
  input busState_e         ctrlState,
  input logic [BYTE_W-1:0] rxByte,
  input logic [ADDR_W-1:0] ptrVal,
  input logic              sdaOe
);

  // R3: drive changes land only while SCL is low
  a_r3_drive_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclSync);

  // R5: an increment moves the pointer by exactly one
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incPtr && !stb.loadPtr) |=> (ptrVal == ADDR_W'($past(ptrVal) + 1)));

  // R5: without a strobe the pointer holds
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.incPtr || stb.loadPtr) |=> $stable(ptrVal));

  // R1: address acknowledge only for a matching device address
  a_r1_ack_match: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_ADDR_ACK) |-> (rxByte[BYTE_W-1:1] == DEV_ADDR));

  // R2: START always returns to address reception
  a_r2_start_restart: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (ctrlState == ST_ADDR));

  // R4: at most one bank or pointer load per cycle
  a_r4_single_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.writeReg, stb.loadPtr, stb.loadTx}));

endmodule

bind i2c_rb_slave i2c_rb_chk #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .startDet(startDet),
  .stb(stb), .ctrlState(ctrlState), .rxByte(rxByte), .ptrVal(ptrVal),
  .sdaOe(sdaOe)
);

// File: tb/i2c_rb_slave_tb.sv
module i2c_rb_slave_tb;

  localparam int Q = 20;  // system clocks per quarter SCL period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic sdaLine;
  int   nChecks = 0;
  int   nFail = 0;
  bit   done = 1'b0;
  bit   oeSeen = 1'b0;

  always #4 clk = ~clk;

  assign sdaLine = sdaM & ~sdaOe;

  i2c_rb_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaOe(sdaOe)
  );

  always @(negedge clk) if (sdaOe) oeSeen <= 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    scl = 1'b1;  waitQ();
    sdaM = 1'b0; waitQ();
    scl = 1'b0;  waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    scl = 1'b1;  waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitQ();
      scl = 1'b1;  waitQ(); waitQ();
      scl = 1'b0;  waitQ();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    sdaM = 1'b1; waitQ();
    scl = 1'b1;  waitQ();
    acked = ~sdaLine;
    waitQ();
    scl = 1'b0;  waitQ();
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      scl = 1'b1; waitQ();
      b[i] = sdaLine;
      waitQ();
      scl = 1'b0;
    end
    waitQ();
    sdaM = giveAck ? 1'b0 : 1'b1;
    waitQ();
    scl = 1'b1; waitQ(); waitQ();
    scl = 1'b0; waitQ();
    sdaM = 1'b1;
  endtask

  task automatic writeSeq(input logic [7:0] p, input logic [7:0] d [4], input int n, input string req);
    bit a;
    busStart();
    sendByte(8'h80, a); check(a, req, a, 1);
    sendByte(p, a);     check(a, req, a, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(d[i], a); check(a, req, a, 1);
    end
    busStop();
  endtask

  task automatic readSeq(input logic [7:0] e [4], input int n, input string req);
    bit a;
    logic [7:0] b;
    busStart();
    sendByte(8'h81, a); check(a, req, a, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, b);
      check(b == e[i], req, b, e[i]);
    end
    busStop();
  endtask

  task automatic t_reset();
    logic [7:0] z [4] = '{8'h00, 8'h00, 8'h00, 8'h00};
    check(sdaOe == 1'b0, "R8 released", sdaOe, 0);
    writeSeq(8'h00, z, 0, "R8");
    readSeq(z, 3, "R8 zero bank");
  endtask

  task automatic t_single();
    logic [7:0] d [4] = '{8'hA5, 8'h00, 8'h00, 8'h00};
    writeSeq(8'h10, d, 1, "R4");
    writeSeq(8'h10, d, 0, "R4");
    readSeq(d, 1, "R6 readback");
  endtask

  task automatic t_multi();
    logic [7:0] d [4] = '{8'h01, 8'h02, 8'h03, 8'h00};
    writeSeq(8'h20, d, 3, "R5");
    writeSeq(8'h20, d, 0, "R5");
    readSeq(d, 3, "R5 sequential");
  endtask

  task automatic t_wrap();
    logic [7:0] d [4] = '{8'h11, 8'h22, 8'h00, 8'h00};
    writeSeq(8'hFF, d, 2, "R5 wrap");
    writeSeq(8'hFF, d, 0, "R5 wrap");
    readSeq(d, 2, "R5 wrap read");
  endtask

  task automatic t_wrongAddr();
    bit a;
    logic [7:0] e [4] = '{8'hA5, 8'h00, 8'h00, 8'h00};
    logic [7:0] z [4] = '{8'h00, 8'h00, 8'h00, 8'h00};
    busStart();
    oeSeen = 1'b0;
    sendByte(8'h82, a); check(!a, "R1 no ack", a, 0);
    sendByte(8'h10, a); check(!a, "R1 ignored", a, 0);
    sendByte(8'hEE, a); check(!a, "R1 ignored", a, 0);
    check(!oeSeen, "R1 never drove", oeSeen, 0);
    busStop();
    busStart();
    sendByte(8'h83, a); check(!a, "R1 read no ack", a, 0);
    busStop();
    writeSeq(8'h10, z, 0, "R1");
    readSeq(e, 1, "R1 bank unchanged");
  endtask

  task automatic t_readContinue();
    bit a;
    logic [7:0] b;
    logic [7:0] z [4] = '{8'h00, 8'h00, 8'h00, 8'h00};
    logic [7:0] e [4] = '{8'h03, 8'h00, 8'h00, 8'h00};
    writeSeq(8'h20, z, 0, "R6");
    busStart();
    sendByte(8'h81, a); check(a, "R6", a, 1);
    recvByte(1'b0, b);  check(b == 8'h01, "R6 first", b, 8'h01);
    waitQ();
    check(sdaOe == 1'b0, "R7 released after nack", sdaOe, 0);
    busStop();
    busStart();
    sendByte(8'h81, a); check(a, "R6", a, 1);
    recvByte(1'b0, b);  check(b == 8'h02, "R6 continues", b, 8'h02);
    busStop();
    readSeq(e, 2, "R7 ack continues");
  endtask

  task automatic t_restart();
    bit a;
    logic [7:0] b;
    logic [7:0] d [4] = '{8'h44, 8'h00, 8'h00, 8'h00};
    logic [7:0] z [4] = '{8'h00, 8'h00, 8'h00, 8'h00};
    busStart();
    sendByte(8'h80, a);
    sendByte(8'h21, a);
    busStart();
    sendByte(8'h81, a); check(a, "R2 repeated start", a, 1);
    recvByte(1'b0, b);  check(b == 8'h02, "R2 repeated start read", b, 8'h02);
    busStop();
    writeSeq(8'h30, d, 1, "R2");
    busStart();
    sendByte(8'h80, a);
    sendByte(8'h30, a);
    sendBits(8'h99, 4);
    busStop();
    writeSeq(8'h30, z, 0, "R2");
    readSeq(d, 1, "R2 stop drops byte");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_wrap();
    t_wrongAddr();
    t_readContinue();
    t_restart();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule